// File: doc/BRIEF.md
# Program-Verify Pulse Sequencer

This block drives the programming of a one-time-programmable word array. The array only lets bits move from 1 to 0, so each target word is written by applying program pulses of fixed width and reading the word back after each pulse. The sequencer walks an address range from a start address to an end address. It moves on from a word as soon as a read-back matches the target. It gives up and reports the address when a word still differs after a bounded number of pulses. When every word has passed, it reads the whole range a second time and raises done only if every word still matches.

A data source supplies the target word for the address currently on the address output. The block presents that word on the full-width write-data bus. The array's read-back word comes in on a separate input. Program pulses are an active-low strobe, and read-back cycles are marked by an active-low output enable. Supply sequencing and margin-mode analog effects are outside the block. A single margin-mode flag stands for them and is held high while a run is in progress.

Top module: `pgm_verify_seq`

## Requirements
- R1: Out of reset, progN and oeN are 1, done, fail and marginMode are 0.
- R2: A start accepted in idle sets marginMode to 1, clears done and fail, loads addr with startAddr and clears the per-word pulse count. marginMode returns to 0 when done or fail is raised.
- R3: Each program pulse holds progN at 0 for exactly PULSE_CYCLES consecutive clock cycles.
- R4: Each pulse is followed by one verify cycle in which oeN is 0, progN is 1, and rdData is compared with srcData for the current addr.
- R5: On a verify match the block applies no further pulse to that word. It steps addr up by one and starts a new pulse with the pulse count cleared. If addr equals endAddr, it starts the check pass instead.
- R6: A word that still mismatches after MAX_PULSES pulses stops the run. fail goes to 1 and addr holds the failing address.
- R7: A target word that needs any bit to go from 0 to 1 cannot pass. It receives exactly MAX_PULSES pulses and then fails with its address on addr.
- R8: The check pass reads each address from startAddr to endAddr once with oeN at 0 and progN at 1. done is raised only if every word matches. The first mismatch raises fail with that address on addr.
- R9: oeN is 1 in every cycle in which progN is 0, and wrData carries all DW bits of srcData.
- R10: start is ignored outside idle. done and fail stay set until the next accepted start, and they are never both 1.
- R11: A range with startAddr equal to endAddr programs and checks that single word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, honoured only in idle |
| startAddr | input | AW | First address of the range |
| endAddr | input | AW | Last address of the range |
| srcData | input | DW | Target word for the current addr |
| rdData | input | DW | Word read back from the array |
| addr | output | AW | Current array address |
| wrData | output | DW | Word presented to the array during programming |
| progN | output | 1 | Program pulse strobe, active low |
| oeN | output | 1 | Read-back output enable, active low |
| marginMode | output | 1 | High while a run is in progress |
| done | output | 1 | Sticky: range programmed and re-checked |
| fail | output | 1 | Sticky: a word failed; addr holds it |

## Verification
The bench builds the block with AW=4 and PULSE_CYCLES=3, and keeps MAX_PULSES at its value of 25. The short pulse makes the exact-width check and a full 25-pulse give-up on a stubborn word cheap, so the complete retry limit is exercised rather than a reduced one. The 16-word space lets the bench cover ranges that start mid-array, a single-word range, a word that needs several pulses, a word that needs an impossible 0-to-1 change, and a word upset between its verify and the check pass.

// File: rtl/pgm_verify_pkg.sv
package pgm_verify_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2,
    ST_CHECK  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadRange;
    logic incAddr;
    logic rewindAddr;
    logic clrTimer;
    logic incTimer;
    logic clrPulse;
    logic incPulse;
  } ctlStrobe_t;

  typedef struct packed {
    logic timerDone;
    logic pulseMax;
    logic match;
    logic atEnd;
  } dpStatus_t;
endpackage

// File: rtl/pgm_verify_dp.sv
module pgm_verify_dp
  import pgm_verify_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int PULSE_CYCLES = 2500,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic          busy,
  input  logic [AW-1:0] startAddr,
  input  logic [AW-1:0] endAddr,
  input  logic [DW-1:0] srcData,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wrData,
  output dpStatus_t     status
);
  localparam int TW = $clog2(PULSE_CYCLES + 1);
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(PULSE_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_LIMIT = CW'(MAX_PULSES);

  logic [AW-1:0] rangeLo, rangeHi;
  logic [TW-1:0] timer;
  logic [CW-1:0] pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr    <= '0;
      rangeLo <= '0;
      rangeHi <= '0;
    end else if (strobe.loadRange) begin
      addr    <= startAddr;
      rangeLo <= startAddr;
      rangeHi <= endAddr;
    end else if (strobe.rewindAddr) begin
      addr <= rangeLo;
    end else if (strobe.incAddr) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                timer <= '0;
    else if (strobe.clrTimer) timer <= '0;
    else if (strobe.incTimer) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strobe.clrPulse) pulseCnt <= '0;
    else if (strobe.incPulse) pulseCnt <= pulseCnt + 1'b1;
  end

  assign wrData           = srcData;
  assign status.timerDone = (timer == TIMER_LAST);
  assign status.pulseMax  = (pulseCnt >= PULSE_LIMIT);
  assign status.match     = (rdData == srcData);
  assign status.atEnd     = (addr == rangeHi);

  // R6: pulse count never passes the retry limit
  p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_LIMIT);

  // R5: address stays inside the latched range while a run is active
  p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (addr >= rangeLo && addr <= rangeHi));
endmodule

// File: rtl/pgm_verify_ctl.sv
module pgm_verify_ctl
  import pgm_verify_pkg::*;
#(
  parameter int PULSE_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       progN,
  output logic       oeN,
  output logic       marginMode,
  output logic       done,
  output logic       fail
);
  localparam int TW = $clog2(PULSE_CYCLES + 2);

  seqState_t state, nextState;
  logic setDone, setFail;

  always_comb begin
    nextState = state;
    strobe    = '0;
    setDone   = 1'b0;
    setFail   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobe.loadRange = 1'b1;
        strobe.clrTimer  = 1'b1;
        strobe.clrPulse  = 1'b1;
        nextState        = ST_PULSE;
      end
      ST_PULSE: if (status.timerDone) begin
        strobe.incPulse = 1'b1;
        nextState       = ST_VERIFY;
      end else begin
        strobe.incTimer = 1'b1;
      end
      ST_VERIFY: if (status.match && status.atEnd) begin
        strobe.rewindAddr = 1'b1;
        nextState         = ST_CHECK;
      end else if (status.match) begin
        strobe.incAddr  = 1'b1;
        strobe.clrPulse = 1'b1;
        strobe.clrTimer = 1'b1;
        nextState       = ST_PULSE;
      end else if (status.pulseMax) begin
        setFail   = 1'b1;
        nextState = ST_IDLE;
      end else begin
        strobe.clrTimer = 1'b1;
        nextState       = ST_PULSE;
      end
      ST_CHECK: if (!status.match) begin
        setFail   = 1'b1;
        nextState = ST_IDLE;
      end else if (status.atEnd) begin
        setDone   = 1'b1;
        nextState = ST_IDLE;
      end else begin
        strobe.incAddr = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      marginMode <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        marginMode <= 1'b1;
        done       <= 1'b0;
        fail       <= 1'b0;
      end else if (setDone || setFail) begin
        marginMode <= 1'b0;
        done       <= setDone;
        fail       <= setFail;
      end
    end
  end

  assign busy  = (state != ST_IDLE);
  assign progN = (state != ST_PULSE);
  assign oeN   = !(state == ST_VERIFY || state == ST_CHECK);

  // Checker counter: consecutive cycles with the strobe low
  logic [TW-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rstN)      lowRun <= '0;
    else if (progN) lowRun <= '0;
    else            lowRun <= lowRun + 1'b1;
  end

  // R3: each strobe lasts exactly PULSE_CYCLES cycles
  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progN) |-> (lowRun == TW'(PULSE_CYCLES)));

  // R4: a strobe is always followed by a read-back cycle
  p_verify_after_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progN) |-> !oeN);

  // R9: never read back while pulsing
  p_oe_off_in_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> oeN);

  // R10: status flags are exclusive and sticky without a start
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail);

  // R2: margin flag is raised during a run and dropped when it ends
  p_margin_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail) |-> !marginMode);
endmodule

// File: rtl/pgm_verify_seq.sv
module pgm_verify_seq
  import pgm_verify_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int PULSE_CYCLES = 2500,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] startAddr,
  input  logic [AW-1:0] endAddr,
  input  logic [DW-1:0] srcData,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wrData,
  output logic          progN,
  output logic          oeN,
  output logic          marginMode,
  output logic          done,
  output logic          fail
);
  ctlStrobe_t strobe;
  dpStatus_t  status;
  logic       busy;

  pgm_verify_ctl #(.PULSE_CYCLES(PULSE_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .status(status),
    .strobe(strobe), .busy(busy), .progN(progN), .oeN(oeN),
    .marginMode(marginMode), .done(done), .fail(fail)
  );

  pgm_verify_dp #(
    .AW(AW), .DW(DW), .PULSE_CYCLES(PULSE_CYCLES), .MAX_PULSES(MAX_PULSES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .startAddr(startAddr), .endAddr(endAddr), .srcData(srcData),
    .rdData(rdData), .addr(addr), .wrData(wrData), .status(status)
  );
endmodule

// File: tb/pgm_verify_seq_test.sv
module pgm_verify_seq_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int PW = 3;
  localparam int MAXP = 25;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] startAddr = '0, endAddr = '0;
  logic [DW-1:0] srcData, rdData, wrData;
  logic [AW-1:0] addr;
  logic progN, oeN, marginMode, done, fail;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] tgt [WORDS];
  int need [WORDS];
  int hits [WORDS];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lowCnt = 0;

  always #10 clk = ~clk;

  pgm_verify_seq #(.AW(AW), .DW(DW), .PULSE_CYCLES(PW), .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .endAddr(endAddr), .srcData(srcData), .rdData(rdData), .addr(addr),
    .wrData(wrData), .progN(progN), .oeN(oeN), .marginMode(marginMode),
    .done(done), .fail(fail)
  );

  assign srcData = tgt[addr];
  assign rdData  = mem[addr];

  // Array model: a word takes its programmed value once it has had enough pulses
  always @(posedge progN) if (rstN) begin
    hits[addr] = hits[addr] + 1;
    if (hits[addr] >= need[addr]) mem[addr] = mem[addr] & wrData;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 pulse, 2 verify, 3 check
  int mPhase = 0, mTimer = 0, mCnt = 0;
  logic [AW-1:0] mAddr = '0, mLo = '0, mHi = '0;
  bit mDone = 0, mFail = 0, mMargin = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mAddr = '0; mDone = 0; mFail = 0; mMargin = 0;
    end else begin
      case (mPhase)
        0: if (start) begin
          mAddr = startAddr; mLo = startAddr; mHi = endAddr;
          mCnt = 0; mTimer = 0; mMargin = 1; mDone = 0; mFail = 0; mPhase = 1;
        end
        1: if (mTimer == PW - 1) begin mCnt++; mPhase = 2; end
           else mTimer++;
        2: if (mem[mAddr] == tgt[mAddr]) begin
             if (mAddr == mHi) begin mAddr = mLo; mPhase = 3; end
             else begin mAddr++; mCnt = 0; mTimer = 0; mPhase = 1; end
           end else if (mCnt >= MAXP) begin
             mFail = 1; mMargin = 0; mPhase = 0;
           end else begin mTimer = 0; mPhase = 1; end
        3: if (mem[mAddr] != tgt[mAddr]) begin
             mFail = 1; mMargin = 0; mPhase = 0;
           end else if (mAddr == mHi) begin
             mDone = 1; mMargin = 0; mPhase = 0;
           end else mAddr++;
        default: mPhase = 0;
      endcase
    end
  end

  // Per-cycle comparison and strobe-width measurement
  always @(negedge clk) if (rstN) begin
    cycles++;
    check(progN == (mPhase != 1), "R3 progN", progN, mPhase != 1);
    check(oeN == !(mPhase == 2 || mPhase == 3), "R4/R8 oeN", oeN, !(mPhase == 2 || mPhase == 3));
    check(addr == mAddr, "R5 addr", addr, mAddr);
    check(done == mDone, "R8 done", done, mDone);
    check(fail == mFail, "R6 fail", fail, mFail);
    check(marginMode == mMargin, "R2 marginMode", marginMode, mMargin);
    check(!((!progN) && (!oeN)), "R9 oe during pulse", oeN, 1);
    check(wrData == tgt[addr], "R9 wrData", wrData, tgt[addr]);
    if (!progN) lowCnt++;
    else if (lowCnt > 0) begin
      check(lowCnt == PW, "R3 pulse width", lowCnt, PW);
      lowCnt = 0;
    end
  end

  task automatic prep();
    for (int a = 0; a < WORDS; a++) begin
      mem[a] = '1;
      tgt[a] = 16'hA5A4 ^ DW'(a << 4);
      need[a] = 1;
      hits[a] = 0;
    end
  endtask

  task automatic launch(input int s, input int e);
    @(negedge clk);
    startAddr = AW'(s); endAddr = AW'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd();
    while (!(done || fail)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    prep();
    repeat (3) @(negedge clk);
    check(progN && oeN && !done && !fail && !marginMode, "R1 reset state",
          {progN, oeN, done, fail, marginMode}, 5'b11000);
    rstN = 1'b1;
    @(negedge clk);

    // Plain range, one pulse per word
    launch(2, 5);
    check(marginMode == 1 && addr == 2, "R2 start loads", addr, 2);
    waitEnd();
    check(done && !fail, "R8 done plain range", done, 1);
    for (int a = 2; a <= 5; a++) check(hits[a] == 1, "R5 no extra pulse", hits[a], 1);

    // Word needing several pulses, with a start request mid-run
    prep(); need[1] = 4;
    launch(0, 3);
    repeat (5) @(negedge clk);
    start = 1'b1; startAddr = 4'd9; endAddr = 4'd12;
    @(negedge clk); start = 1'b0;
    waitEnd();
    check(done && hits[1] == 4, "R5 multi-pulse word", hits[1], 4);
    check(hits[9] == 0, "R10 start ignored when busy", hits[9], 0);
    repeat (4) @(negedge clk);
    check(done, "R10 done sticky", done, 1);

    // Word that would need a 0-to-1 change
    prep(); mem[5] = 16'hFFFB;
    launch(4, 6);
    waitEnd();
    check(fail && !done && addr == 5, "R7 impossible word fails", addr, 5);
    check(hits[5] == MAXP, "R6 pulse limit", hits[5], MAXP);
    check(hits[6] == 0, "R6 run stops", hits[6], 0);

    // Word upset after its verify, caught by the check pass
    prep();
    launch(8, 10);
    while (addr != 4'd9) @(negedge clk);
    mem[8] = mem[8] | 16'h0001;
    waitEnd();
    check(fail && addr == 8, "R8 check pass failure", addr, 8);

    // Single-word range clears sticky fail
    prep();
    launch(15, 15);
    check(!fail, "R10 fail cleared by start", fail, 0);
    waitEnd();
    check(done && hits[15] == 1 && mem[15] == tgt[15], "R11 single word", mem[15], tgt[15]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule